// File: doc/BRIEF.md
# Ethernet Controller Bring-Up Sequencer

This block brings a MAC with banked registers and an attached PHY from power-on to a known, running state. After reset it waits a long power-settle interval. It then performs a fixed series of register writes over a simple request/acknowledge write port. These writes pulse the MAC soft reset, wait a second settle interval, and turn on the MAC power-enable bit. Before a write to a new register bank, the block first writes the bank-select register.

Next, the block drives a management-interface command port. It writes the PHY reset bit and polls the PHY control register until the reset bit clears. It then reads every PHY register, in ascending order, into a local store that an index input can read. The block raises `ready` when the dump is complete. If the PHY stays busy for too many polls, it raises `err` instead. Both flags hold until the next reset. The MAC bus cycle and the serial bit timing of the management interface are handled by neighbouring blocks. Both delay lengths are parameters, so a simulation can shorten them.

Top module: `init_seq`

## Requirements
- R1: While reset is asserted, and for at least PWR_DELAY cycles after it is released, neither `wr_req` nor `mdio_req` is asserted. During this time `ready` and `err` are low, and `dump_val` reads 0 for every index.
- R2: The MAC writes arrive in exactly this order, as (offset, data) pairs: (0xE, 0x0000), (0x4, 0x8000), (0x4, 0x0000), (0xE, 0x0001), (0x0, 0xA0B1). Offset 0xE is the bank-select register, and it carries the bank number in its low two bits with zeros above.
- R3: A bank-select write is issued before the first register write after reset. After that, one is issued only when the next write targets a bank other than the one last selected. So the second write to bank 0 is not preceded by a bank select.
- R4: Once `wr_req` or `mdio_req` is high, it stays high, with its address, data and direction unchanged, until a cycle in which the matching `wr_ack` or `mdio_done` is high.
- R5: After the acknowledge of the soft-reset release write (offset 0x4, data 0x0000), no request is made for at least SETTLE_DELAY cycles.
- R6: After the power-enable write is acknowledged, the first management command writes 0x8000 to PHY register 0.
- R7: Next, PHY register 0 is read again and again, as long as the returned bit 15 is 1. The first read that returns bit 15 at 0 ends the polling.
- R8: If MAX_POLLS consecutive polls return bit 15 at 1, `err` rises and stays high. No further request follows, and `ready` stays low.
- R9: After a successful poll, PHY registers 0 through 2^PHY_AW-1 are read in ascending order. `dump_val` at index `dump_sel` shows the value returned for that register.
- R10: `ready` rises after the last dump read and stays high. `err` stays low, and no further request is made.
- R11: `wr_req` and `mdio_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | output | 1 | MAC register write request |
| wr_addr | output | 4 | MAC register offset |
| wr_data | output | 16 | MAC register write data |
| wr_ack | input | 1 | MAC write accepted (one cycle) |
| mdio_req | output | 1 | Management command request |
| mdio_wr | output | 1 | 1 = write command, 0 = read |
| mdio_reg | output | PHY_AW | PHY register number |
| mdio_wdata | output | 16 | PHY write data |
| mdio_done | input | 1 | Management command finished (one cycle) |
| mdio_rdata | input | 16 | Read data, valid with `mdio_done` |
| dump_sel | input | PHY_AW | Index into the readback store |
| dump_val | output | 16 | Stored readback of register `dump_sel` |
| ready | output | 1 | Bring-up complete |
| err | output | 1 | PHY reset poll timed out |

## Verification
Two outcomes can meet on the same poll response: the PHY clearing its reset bit, and the poll limit being reached. On the poll that would exhaust the limit, a cleared bit must still win. The bench runs the PHY model busy for exactly MAX_POLLS-1 polls, which must end in a full dump and `ready`. It then runs it busy for exactly MAX_POLLS polls, which must end in `err` with no dump. Random busy counts around that boundary, together with random acknowledge latencies (zero included), repeat the judgement against the logged transaction order.

// File: rtl/init_pkg.sv
package init_pkg;

  localparam int BANK_W = 2;
  localparam int MAC_DW = 16;
  localparam int NUM_STEPS = 3;
  localparam logic [3:0] BSEL_OFS = 4'hE;
  localparam logic [MAC_DW-1:0] PHY_RESET_CMD = 16'h8000;
  localparam int PHY_BUSY_BIT = 15;

  typedef enum logic [3:0] {
    ST_PWR_WAIT,
    ST_STEP,
    ST_BSEL,
    ST_REG_WR,
    ST_SETTLE,
    ST_PHY_RST,
    ST_POLL,
    ST_DUMP,
    ST_READY,
    ST_FAIL
  } seq_state_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [3:0]        ofs;
    logic [MAC_DW-1:0] data;
    logic              settle;
  } mac_step_t;

  // Ordered MAC write program; settle marks a long wait after the write.
  function automatic mac_step_t mac_step(input logic [1:0] idx);
    mac_step_t s;
    case (idx)
      2'd0:    s = '{bank: 2'd0, ofs: 4'h4, data: 16'h8000, settle: 1'b0};
      2'd1:    s = '{bank: 2'd0, ofs: 4'h4, data: 16'h0000, settle: 1'b1};
      default: s = '{bank: 2'd1, ofs: 4'h0, data: 16'hA0B1, settle: 1'b0};
    endcase
    return s;
  endfunction

  function automatic logic [MAC_DW-1:0] bank_word(input logic [BANK_W-1:0] b);
    return {{(MAC_DW-BANK_W){1'b0}}, b};
  endfunction

  function automatic logic bank_change(input logic valid,
                                       input logic [BANK_W-1:0] cur,
                                       input logic [BANK_W-1:0] want);
    return !valid || (cur != want);
  endfunction

  function automatic logic phy_busy(input logic [MAC_DW-1:0] v);
    return v[PHY_BUSY_BIT];
  endfunction

endpackage

// File: rtl/init_delay_timer.sv
module init_delay_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  assign expired = en && (cnt == limit - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (!expired) cnt <= cnt + TW'(1);
  end
endmodule

// File: rtl/init_bank_tracker.sv
module init_bank_tracker
  import init_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [BANK_W-1:0] want_bank,
  output logic              need_sel
);
  logic              valid;
  logic [BANK_W-1:0] cur;

  assign need_sel = bank_change(valid, cur, want_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cur   <= '0;
    end else if (upd) begin
      valid <= 1'b1;
      cur   <= want_bank;
    end
  end
endmodule

// File: rtl/init_dump_store.sv
module init_dump_store #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;
  logic [DW-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (we && widx == AW'(g)) mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/init_seq.sv
module init_seq
  import init_pkg::*;
#(
  parameter int PWR_DELAY    = 50_000_000,
  parameter int SETTLE_DELAY = 50_000_000,
  parameter int MAX_POLLS    = 64,
  parameter int PHY_AW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              wr_req,
  output logic [3:0]        wr_addr,
  output logic [15:0]       wr_data,
  input  logic              wr_ack,
  output logic              mdio_req,
  output logic              mdio_wr,
  output logic [PHY_AW-1:0] mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic              mdio_done,
  input  logic [15:0]       mdio_rdata,
  input  logic [PHY_AW-1:0] dump_sel,
  output logic [15:0]       dump_val,
  output logic              ready,
  output logic              err
);
  localparam int MAXD = (PWR_DELAY > SETTLE_DELAY) ? PWR_DELAY : SETTLE_DELAY;
  localparam int TW   = $clog2(MAXD + 1);
  localparam int PCW  = $clog2(MAX_POLLS + 1);
  localparam logic [PHY_AW-1:0] LAST_REG = {PHY_AW{1'b1}};

  seq_state_e        state;
  logic [1:0]        step_idx;
  logic [PCW-1:0]    poll_cnt;
  logic [PHY_AW-1:0] dump_idx;
  mac_step_t         cur_step;

  // Named internal events (also observed by the checker)
  logic in_wait, timer_done, need_bsel;
  logic bsel_ack_evt, reg_ack_evt, last_step;
  logic poll_done_evt, poll_busy_evt, poll_limit_evt, dump_store_evt;
  logic [TW-1:0] timer_limit;

  assign cur_step       = mac_step(step_idx);
  assign last_step      = (step_idx == 2'(NUM_STEPS - 1));
  assign in_wait        = (state == ST_PWR_WAIT) || (state == ST_SETTLE);
  assign timer_limit    = (state == ST_PWR_WAIT) ? TW'(PWR_DELAY) : TW'(SETTLE_DELAY);
  assign bsel_ack_evt   = (state == ST_BSEL) && wr_ack;
  assign reg_ack_evt    = (state == ST_REG_WR) && wr_ack;
  assign poll_done_evt  = (state == ST_POLL) && mdio_done;
  assign poll_busy_evt  = poll_done_evt && phy_busy(mdio_rdata);
  assign poll_limit_evt = poll_busy_evt && (poll_cnt == PCW'(MAX_POLLS - 1));
  assign dump_store_evt = (state == ST_DUMP) && mdio_done;

  init_delay_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_wait),
    .limit   (timer_limit),
    .expired (timer_done)
  );

  init_bank_tracker u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (bsel_ack_evt),
    .want_bank (cur_step.bank),
    .need_sel  (need_bsel)
  );

  init_dump_store #(.AW(PHY_AW), .DW(16)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dump_store_evt),
    .widx  (dump_idx),
    .wdata (mdio_rdata),
    .ridx  (dump_sel),
    .rdata (dump_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_PWR_WAIT;
      step_idx <= '0;
      poll_cnt <= '0;
      dump_idx <= '0;
    end else begin
      case (state)
        ST_PWR_WAIT: if (timer_done) state <= ST_STEP;
        ST_STEP:     state <= need_bsel ? ST_BSEL : ST_REG_WR;
        ST_BSEL:     if (wr_ack) state <= ST_REG_WR;
        ST_REG_WR: if (wr_ack) begin
          step_idx <= step_idx + 2'd1;
          if (cur_step.settle) state <= ST_SETTLE;
          else if (last_step)  state <= ST_PHY_RST;
          else                 state <= ST_STEP;
        end
        ST_SETTLE:   if (timer_done) state <= ST_STEP;
        ST_PHY_RST: if (mdio_done) begin
          state    <= ST_POLL;
          poll_cnt <= '0;
        end
        ST_POLL: if (mdio_done) begin
          if (!phy_busy(mdio_rdata)) begin
            state    <= ST_DUMP;
            dump_idx <= '0;
          end else if (poll_limit_evt) begin
            state <= ST_FAIL;
          end else begin
            poll_cnt <= poll_cnt + PCW'(1);
          end
        end
        ST_DUMP: if (mdio_done) begin
          if (dump_idx == LAST_REG) state <= ST_READY;
          else dump_idx <= dump_idx + PHY_AW'(1);
        end
        ST_READY: state <= ST_READY;
        ST_FAIL:  state <= ST_FAIL;
        default:  state <= ST_FAIL;
      endcase
    end
  end

  // Request ports, decoded from registered state
  always_comb begin
    wr_req     = (state == ST_BSEL) || (state == ST_REG_WR);
    wr_addr    = (state == ST_BSEL) ? BSEL_OFS : cur_step.ofs;
    wr_data    = (state == ST_BSEL) ? bank_word(cur_step.bank) : cur_step.data;
    mdio_req   = (state == ST_PHY_RST) || (state == ST_POLL) || (state == ST_DUMP);
    mdio_wr    = (state == ST_PHY_RST);
    mdio_reg   = (state == ST_DUMP) ? dump_idx : '0;
    mdio_wdata = (state == ST_PHY_RST) ? PHY_RESET_CMD : '0;
  end

  assign ready = (state == ST_READY);
  assign err   = (state == ST_FAIL);

endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk
  import init_pkg::*;
#(
  parameter int PHY_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [3:0]        wr_addr,
  input logic [15:0]       wr_data,
  input logic              mdio_req,
  input logic              mdio_done,
  input logic              mdio_wr,
  input logic [PHY_AW-1:0] mdio_reg,
  input logic [15:0]       mdio_wdata,
  input logic              ready,
  input logic              err,
  input logic              in_wait,
  input logic              poll_limit_evt
);

  p_quiet_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !wr_req && !mdio_req);

  p_bsel_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_addr == BSEL_OFS) |-> (wr_data[15:BANK_W] == '0));

  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  p_mdio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_done) |=>
      mdio_req && $stable(mdio_wr) && $stable(mdio_reg) && $stable(mdio_wdata));

  p_limit_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_limit_evt |=> err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !ready && !wr_req && !mdio_req);

  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready && !err && !wr_req && !mdio_req);

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && mdio_req));

endmodule

bind init_seq init_seq_chk #(.PHY_AW(PHY_AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_req         (wr_req),
  .wr_ack         (wr_ack),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .mdio_req       (mdio_req),
  .mdio_done      (mdio_done),
  .mdio_wr        (mdio_wr),
  .mdio_reg       (mdio_reg),
  .mdio_wdata     (mdio_wdata),
  .ready          (ready),
  .err            (err),
  .in_wait        (in_wait),
  .poll_limit_evt (poll_limit_evt)
);

// File: tb/test_init_seq.sv
module test_init_seq;
  localparam int PWR  = 40;
  localparam int SET  = 25;
  localparam int MAXP = 4;
  localparam int AW   = 5;
  localparam int NR   = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr_req, wr_ack, mdio_req, mdio_wr, mdio_done, ready, err;
  logic [3:0]    wr_addr;
  logic [15:0]   wr_data, mdio_wdata, mdio_rdata, dump_val;
  logic [AW-1:0] mdio_reg, dump_sel;

  init_seq #(.PWR_DELAY(PWR), .SETTLE_DELAY(SET), .MAX_POLLS(MAXP), .PHY_AW(AW)) i_init_seq (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
    .dump_sel(dump_sel), .dump_val(dump_val), .ready(ready), .err(err));

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Responder / logging state
  int cyc, wn, mn, wlat, mlat, busy_left;
  int first_req_cyc, settle_ack_cyc, after_settle_cyc, overlap, hold_err;
  bit wpend, mpend;
  logic [3:0]    w_addr_log [16];
  logic [15:0]   w_data_log [16];
  logic          m_wr_log   [80];
  logic [AW-1:0] m_reg_log  [80];
  logic [15:0]   m_wd_log   [80];
  logic [15:0]   phy_model  [NR];
  logic [3:0]    hold_a;
  logic [15:0]   hold_d;
  logic [AW-1:0] hold_r;

  initial begin : responder
    wr_ack = 1'b0; mdio_done = 1'b0; mdio_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        wr_ack = 1'b0; mdio_done = 1'b0; cyc = 0; wpend = 0; mpend = 0;
      end else begin
        cyc++;
        if (wr_req && mdio_req) overlap++;
        // MAC write port
        if (wr_ack) wr_ack = 1'b0;
        else if (wr_req) begin
          if (first_req_cyc < 0) first_req_cyc = cyc;
          if (wn == 3 && after_settle_cyc < 0) after_settle_cyc = cyc;
          if (!wpend) begin wpend = 1; hold_a = wr_addr; hold_d = wr_data; end
          else if (hold_a != wr_addr || hold_d != wr_data) hold_err++;
          if (wlat == 0) begin
            if (wn < 16) begin w_addr_log[wn] = wr_addr; w_data_log[wn] = wr_data; end
            if (wn == 2) settle_ack_cyc = cyc;
            wn++; wr_ack = 1'b1; wpend = 0;
            wlat = $urandom_range(0, 3);
          end else wlat--;
        end
        // Management port
        if (mdio_done) mdio_done = 1'b0;
        else if (mdio_req) begin
          if (first_req_cyc < 0) first_req_cyc = cyc;
          if (!mpend) begin mpend = 1; hold_r = mdio_reg; end
          else if (hold_r != mdio_reg) hold_err++;
          if (mlat == 0) begin
            if (mn < 80) begin
              m_wr_log[mn] = mdio_wr; m_reg_log[mn] = mdio_reg; m_wd_log[mn] = mdio_wdata;
            end
            if (!mdio_wr && mdio_reg == '0 && busy_left > 0) begin
              mdio_rdata = 16'h8000 | 16'($urandom_range(0, 16'h7fff));
              busy_left--;
            end else mdio_rdata = phy_model[mdio_reg];
            mn++; mdio_done = 1'b1; mpend = 0;
            mlat = $urandom_range(0, 3);
          end else mlat--;
        end
      end
    end
  end

  // Expected MAC program (R2/R3): bank sel 0, two bank-0 writes, bank sel 1, power enable
  function automatic logic [3:0] exp_addr(input int i);
    case (i) 0: return 4'hE; 1: return 4'h4; 2: return 4'h4; 3: return 4'hE; default: return 4'h0; endcase
  endfunction
  function automatic logic [15:0] exp_data(input int i);
    case (i) 0: return 16'h0000; 1: return 16'h8000; 2: return 16'h0000; 3: return 16'h0001;
      default: return 16'hA0B1; endcase
  endfunction
  function automatic int exp_polls(input int busy);
    return (busy >= MAXP) ? MAXP : busy + 1;
  endfunction

  task automatic run(input int busy);
    int n, np, wn0, mn0;
    bit fail_exp;
    rst_n = 1'b0;
    busy_left = busy; wn = 0; mn = 0; wlat = 0; mlat = 0;
    first_req_cyc = -1; settle_ack_cyc = -1; after_settle_cyc = -1;
    overlap = 0; hold_err = 0;
    for (int i = 0; i < NR; i++) phy_model[i] = 16'($urandom);
    phy_model[0] = phy_model[0] & 16'h7fff;
    repeat (3) @(negedge clk);
    #1;
    chk(!ready && !err && !wr_req && !mdio_req, "R1", "outputs in reset",
        {ready, err, wr_req, mdio_req}, 0);
    dump_sel = AW'($urandom_range(0, NR - 1));
    #1;
    chk(dump_val == 16'h0, "R1", "dump_val in reset", dump_val, 0);
    rst_n = 1'b1;
    n = 0;
    while (!(ready || err) && n < 5000) begin @(negedge clk); n++; end
    #2;
    chk(n < 5000, "R10", "completion", n, 5000);
    chk(first_req_cyc >= PWR, "R1", "first request cycle", first_req_cyc, PWR);
    chk(after_settle_cyc - settle_ack_cyc >= SET, "R5", "settle gap",
        after_settle_cyc - settle_ack_cyc, SET);
    chk(wn == 5, "R2", "MAC write count", wn, 5);
    for (int i = 0; i < 5; i++)
      chk(w_addr_log[i] == exp_addr(i) && w_data_log[i] == exp_data(i),
          (i == 0 || i == 3) ? "R3" : "R2", "MAC write",
          {w_addr_log[i], w_data_log[i]}, {exp_addr(i), exp_data(i)});
    chk(hold_err == 0, "R4", "request hold", hold_err, 0);
    chk(overlap == 0, "R11", "port overlap", overlap, 0);
    chk(m_wr_log[0] && m_reg_log[0] == '0 && m_wd_log[0] == 16'h8000, "R6",
        "PHY reset write", {m_wr_log[0], m_reg_log[0], m_wd_log[0]}, {1'b1, 5'd0, 16'h8000});
    np = exp_polls(busy);
    for (int i = 1; i <= np; i++)
      chk(!m_wr_log[i] && m_reg_log[i] == '0, "R7", "poll read of reg 0",
          {m_wr_log[i], m_reg_log[i]}, 0);
    fail_exp = (busy >= MAXP);
    if (fail_exp) begin
      chk(err && !ready, "R8", "timeout flags", {err, ready}, 2);
      chk(mn == 1 + MAXP, "R8", "command count", mn, 1 + MAXP);
    end else begin
      chk(ready && !err, "R10", "ready flags", {ready, err}, 2);
      chk(mn == 1 + np + NR, "R9", "command count", mn, 1 + np + NR);
      for (int i = 0; i < NR; i++)
        chk(!m_wr_log[1 + np + i] && m_reg_log[1 + np + i] == AW'(i), "R9", "dump order",
            m_reg_log[1 + np + i], i);
      for (int i = 0; i < NR; i++) begin
        dump_sel = AW'(i);
        #1;
        chk(dump_val == phy_model[i], "R9", "dump_val", dump_val, phy_model[i]);
      end
    end
    wn0 = wn; mn0 = mn;
    repeat (30) @(negedge clk);
    #2;
    chk(wn == wn0 && mn == mn0, fail_exp ? "R8" : "R10", "no later requests",
        wn + mn, wn0 + mn0);
    chk(ready == !fail_exp && err == fail_exp, fail_exp ? "R8" : "R10", "flags held",
        {ready, err}, {!fail_exp, fail_exp});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    dump_sel = '0;
    run(0);
    run(MAXP - 1);  // limit and clear meet: must succeed
    run(MAXP);      // limit reached while still busy: must fail
    run(MAXP + 3);
    for (int k = 0; k < 5; k++) run($urandom_range(0, MAXP + 1));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule